// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block turns a configuration byte into a stream of single-cycle toggle strobes for a SPI shift engine. Each strobe marks one half period of the serial clock, so the shift engine flips SCK on every strobe. The clock frequency is the core clock divided by a divisor taken from the byte. The divisor can be coded in one of two ways, and a parameter picks the coding when the block is built.

The extended coding builds the divisor as a 4-bit mantissa times a power of two. The 3-bit exponent is split across the byte, because a neighbouring bit carries the word size. The legacy coding uses a 5-bit code that holds 0x10 plus half of an even divisor from 4 to 30. A floor parameter raises any smaller divisor for integrations that need a larger minimum, such as 15. While `run` is high the block counts half periods. It restarts cleanly each time `run` rises.

Top module: `sck_prescaler`

## Requirements
- R1: With EXT_MODE=1 the mantissa is cfg[3:0] and the exponent is {cfg[7], cfg[6], cfg[4]}, where cfg[4] is the exponent's least significant bit. The divisor is mantissa × 2^exponent.
- R2: With EXT_MODE=1 a mantissa of 0 is used as 1.
- R3: Bits outside the active field have no effect on the strobes: cfg[5] with EXT_MODE=1, and cfg[7:5] with EXT_MODE=0.
- R4: With EXT_MODE=0 a code cfg[4:0] of 0x12 or more gives the divisor 2 × (code − 0x10), so 0x1F gives 30. A code below 0x12 gives the divisor 4.
- R5: A decoded divisor below MIN_DIV is raised to MIN_DIV. MIN_DIV values below 2 act as 2.
- R6: Each `tick` lasts one cycle. While running, the gaps between ticks alternate between floor(D/2) cycles and ceil(D/2) cycles, starting with floor(D/2). Every two ticks therefore span exactly D cycles.
- R7: If the clock edge at which `run` is first seen high is counted as edge 0, the first tick is high in the cycle after edge floor(D/2) − 1.
- R8: `tick` stays low during reset and while `run` is low. It falls at the first edge that samples `run` low.
- R9: With EXT_MODE=1 the largest divisor is 1920 (cfg = 0xDF), and the count reaches it without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 8 | Raw prescale configuration byte; hold it stable while run is high |
| run | input | 1 | Count enable; a rising level restarts the half-period count |
| tick | output | 1 | One-cycle strobe at each SCK half-period boundary |

## Verification
The bench drives three builds of the block with the same stimulus. The first uses the extended coding with the default floor of 2, which makes the divisor-2 clamp and the odd divisors 3 and 5 reachable. The second uses the extended coding with a floor of 15, which shows a small mantissa raised to the stricter minimum. The third uses the legacy coding, which covers the even half-divisor codes, the clamp below 0x12 and the ignored upper bits. Every tick from each build is compared to the exact cycle that the divisor rules predict, including the 1920-cycle extreme.

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter bit EXT_MODE = 1'b1,
  parameter int MIN_DIV  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic       run,
  output logic       tick
);
  localparam int MANT_W  = 4;
  localparam int EXP_W   = 3;
  localparam int DIV_W   = MANT_W + (1 << EXP_W) - 1;
  localparam int MIN_EFF = (MIN_DIV < 2) ? 2 : MIN_DIV;
  localparam int MAX_RAW = EXT_MODE ? ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1) : 30;
  localparam int MAX_DIV = (MAX_RAW > MIN_EFF) ? MAX_RAW : MIN_EFF;

  logic [DIV_W-1:0] raw_div, div, half_lo, half_hi, cnt;
  logic             act, phase;

  generate
    if (EXT_MODE) begin : g_ext
      logic [MANT_W-1:0] mant;
      logic [EXP_W-1:0]  expo;
      assign mant    = (cfg[3:0] == '0) ? MANT_W'(1) : cfg[3:0];
      assign expo    = {cfg[7:6], cfg[4]};
      assign raw_div = DIV_W'(mant) << expo;
    end else begin : g_leg
      logic [4:0] code;
      assign code    = cfg[4:0];
      assign raw_div = (code < 5'h12) ? DIV_W'(4) : DIV_W'({code - 5'h10, 1'b0});

      assert_legacy_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_div[0] && raw_div >= DIV_W'(4) && raw_div <= DIV_W'(30));
    end
  endgenerate

  assign div     = (raw_div < DIV_W'(MIN_EFF)) ? DIV_W'(MIN_EFF) : raw_div;
  assign half_lo = div >> 1;
  assign half_hi = div - half_lo;
  assign tick    = act && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      phase <= 1'b0;
      cnt   <= '0;
    end else begin
      act <= run;
      if (run && !act) begin
        cnt   <= half_lo - 1'b1;
        phase <= 1'b0;
      end else if (act) begin
        if (cnt == '0) begin
          cnt   <= phase ? half_lo - 1'b1 : half_hi - 1'b1;
          phase <= ~phase;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_tick_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(run));

  assert_div_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div >= DIV_W'(MIN_EFF) && div <= DIV_W'(MAX_DIV));

  assert_first_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act) |=> (!tick || $past(half_lo) == DIV_W'(1)));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act && $stable(cfg) && $past(act) |-> cnt < half_hi);
endmodule

// File: tb/tb_sck_prescaler.sv
module tb_sck_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       run = 1'b0;
  logic       tk_ext, tk_v15, tk_leg;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;
  string      cur = "R8";
  int         q_ext[$], q_v15[$], q_leg[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sck_prescaler #(.EXT_MODE(1'b1), .MIN_DIV(2))  dut     (.clk(clk), .rst_n(rst_n), .cfg(cfg), .run(run), .tick(tk_ext));
  sck_prescaler #(.EXT_MODE(1'b1), .MIN_DIV(15)) dut_v15 (.clk(clk), .rst_n(rst_n), .cfg(cfg), .run(run), .tick(tk_v15));
  sck_prescaler #(.EXT_MODE(1'b0), .MIN_DIV(4))  dut_leg (.clk(clk), .rst_n(rst_n), .cfg(cfg), .run(run), .tick(tk_leg));

  function automatic int exp_div(bit ext, int mn, logic [7:0] c);
    int d;
    if (ext) begin
      int m = int'(c[3:0]);
      int e = int'({c[7:6], c[4]});
      if (m == 0) m = 1;
      d = m << e;
    end else begin
      int code = int'(c[4:0]);
      d = (code < 18) ? 4 : 2 * (code - 16);
    end
    if (d < mn) d = mn;
    return d;
  endfunction

  task automatic push(ref int q[$], input int d, input int c0, input int w);
    int lo = d / 2;
    int hi = d - lo;
    int t = c0 + lo - 1;
    bit ph = 1'b0;
    while (t <= c0 + w - 1) begin
      q.push_back(t);
      t += ph ? lo : hi;
      ph = ~ph;
    end
  endtask

  task automatic monitor(input logic tk, ref int q[$], input string nm);
    if (tk) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s %s: tick at cycle %0d, expected no tick", cur, nm, cyc);
      end else begin
        int e = q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s %s: tick at cycle %0d, expected cycle %0d", cur, nm, cyc, e);
        end
      end
    end else if (q.size() > 0 && q[0] < cyc) begin
      int e = q.pop_front();
      checks++;
      fails++;
      $display("FAIL %s %s: no tick at cycle %0d, expected tick at %0d", cur, nm, cyc, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      monitor(tk_ext, q_ext, "ext");
      monitor(tk_v15, q_v15, "v15");
      monitor(tk_leg, q_leg, "leg");
    end
  end

  task automatic run_case(input logic [7:0] c, input int w, input string tag);
    int c0;
    @(negedge clk);
    cur = tag;
    cfg = c;
    run = 1'b1;
    @(posedge clk);
    #1;
    c0 = cyc;
    push(q_ext, exp_div(1'b1, 2, c), c0, w);
    push(q_v15, exp_div(1'b1, 15, c), c0, w);
    push(q_leg, exp_div(1'b0, 4, c), c0, w);
    @(negedge clk);
    while (cyc < c0 + w - 1) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (q_ext.size() + q_v15.size() + q_leg.size() != 0) begin
      fails++;
      $display("FAIL %s cfg=%h: %0d expected ticks left, expected 0", tag, c,
               q_ext.size() + q_v15.size() + q_leg.size());
      q_ext.delete(); q_v15.delete(); q_leg.delete();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({tk_ext, tk_v15, tk_leg} != 3'b000) begin
      fails++;
      $display("FAIL R8 reset: ticks %b, expected 000", {tk_ext, tk_v15, tk_leg});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if ({tk_ext, tk_v15, tk_leg} != 3'b000) begin
      fails++;
      $display("FAIL R8 idle: ticks %b, expected 000", {tk_ext, tk_v15, tk_leg});
    end
    run_case(8'h03, 200, "R6");   // odd divisors 3 and 15, legacy clamp to 4
    run_case(8'h00, 200, "R2");   // mantissa 0 -> 1, raised to 2 (R5)
    run_case(8'h25, 200, "R3");   // bit5 ignored in extended mode
    run_case(8'h1A, 300, "R4");   // legacy 20, extended 10*2
    run_case(8'h12, 200, "R7");   // divisor 4 in all coding paths
    run_case(8'h47, 300, "R1");   // exponent bits 7:6 = 01 -> exp 2
    run_case(8'h91, 300, "R1");   // exponent {1,0,1} = 5 -> 32
    run_case(8'hF7, 200, "R3");   // legacy bits 7:5 ignored -> code 0x17
    run_case(8'h1F, 300, "R4");   // legacy max 30
    run_case(8'h05, 200, "R5");   // min 15 floor on 5
    run_case(8'hDF, 4000, "R9");  // 1920
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end
endmodule